// File: doc/BRIEF.md
# Memory Reference Annotation Register

This block keeps a short row of cache hints that software loads ahead of the memory operations they refer to. A tag instruction delivers an immediate word; its low twenty-four bits are split into six 4-bit hint fields. Each later load or store, in program order, is handed the least significant field that is still waiting, and the row then moves down by one field, with zeros entering at the top. Zero is the default hint, so memory operations that arrive with nothing pending behave normally.

Up to two memory operations read hints in one execute cycle. A tag write in the same cycle is taken as landing before those reads, so the reads are served from the new word. The block also holds the issue-stage interlock: a tag in the candidate issue group must wait if a memory operation older than it is in that same group, because that operation would otherwise read its hint after the tag had overwritten the row.

The store runs a two-state machine. `ST_EMPTY` means no fields are pending and every read gets zero. `ST_HOLD` means at least one loaded field has not yet been consumed. The transition `EMPTY->HOLD` fires on any tag write. `HOLD->HOLD` covers partial consumption and reloads. `HOLD->EMPTY` fires when the reads of a cycle use up the last pending field and no tag arrives in that cycle.

Top module: `mhint_annot_unit`

## Requirements
- R1: After reset, every memory read gets hint 0 until a tag write occurs.
- R2: A single memory read gets the lowest pending 4-bit field (bits [3:0] of the row). The row then moves down by 4 bits.
- R3: Once all six fields of a tag have been consumed, further reads get hint 0. Zeros fill the row from the top.
- R4: Bits [25:24] of the tag immediate have no effect on any hint.
- R5: When both read slots are valid, slot 0 (older) gets bits [3:0] and slot 1 gets bits [7:4]. The row then moves down by 8 bits.
- R6: A slot whose read valid is low outputs hint 0. A lone valid read in slot 1 gets the lowest pending field.
- R7: A tag write in the same cycle as reads serves those reads from the new immediate, starting at its bits [3:0]. Any fields left over from the previous tag are discarded.
- R8: A tag write with no reads loads all six fields. The following reads return them in order, from bits [3:0] up to bits [23:20].
- R9: `issue_stall_o` is high when the candidate group has a tag at position p and a memory operation at some position q < p. Position 0 is the oldest.
- R10: `issue_stall_o` is low when the group has no tag, or when every memory operation in the group is younger than the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_wr_i | input | 1 | Tag write in this cycle |
| tag_imm_i | input | 26 | Tag immediate; bits [23:0] hold six 4-bit fields |
| mem_rd_i | input | 2 | Read valid per execute slot, slot 0 oldest |
| mem_hint_o | output | 8 | Hint per slot; slot s uses bits [4s+3:4s] |
| grp_tag_i | input | 4 | Candidate issue group: position holds a tag |
| grp_mem_i | input | 4 | Candidate issue group: position holds a memory op |
| issue_stall_o | output | 1 | Hold the tag in the slotting stage |

## Verification
On every cycle, the embedded assertions check three things: the empty state implies an all-zero row, a tag write is bypassed to a coincident slot-0 read, and the row stays stable when nothing touches it. They also check that a group without a tag never stalls, and that a dual read shifts the row by two fields. The ordering of fields across many reads can only be shown by the bench's scenarios and its per-cycle queue model. The same holds for discarding old fields on a reload, for the lone slot-1 read, for ignoring the spare immediate bits, and for the interlock's positional cases.

// File: rtl/mhint_pkg.sv
package mhint_pkg;
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } hint_state_e;
endpackage

// File: rtl/mhint_interlock.sv
module mhint_interlock #(
    parameter int GRP_W = 4
) (
    input  logic [GRP_W-1:0] grp_tag_i,
    input  logic [GRP_W-1:0] grp_mem_i,
    output logic             stall_o
);
    // Walk the group from oldest to youngest, remembering whether a
    // memory op has been seen; a tag after one must wait.
    always_comb begin
        logic older_mem;
        older_mem = 1'b0;
        stall_o   = 1'b0;
        for (int i = 0; i < GRP_W; i++) begin
            if (grp_tag_i[i] && older_mem) stall_o = 1'b1;
            older_mem = older_mem | grp_mem_i[i];
        end
    end
endmodule

// File: rtl/mhint_store.sv
module mhint_store
    import mhint_pkg::*;
#(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 6,
    parameter int SLOTS      = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tag_wr_i,
    input  logic [FIELD_W*NUM_FIELDS-1:0] tag_fields_i,
    input  logic [SLOTS-1:0]           rd_i,
    output logic [SLOTS*FIELD_W-1:0]   hint_o
);
    localparam int STORE_W = FIELD_W * NUM_FIELDS;
    localparam int CNT_W   = $clog2(NUM_FIELDS + 1);

    hint_state_e         state_q, state_d;
    logic [STORE_W-1:0]  row_q, row_d, eff_row;
    logic [CNT_W-1:0]    cnt_q, cnt_d, eff_cnt;
    logic [FIELD_W-1:0]  hint_arr [SLOTS];
    logic [CNT_W-1:0]    nread;

    // Write lands in the first half: reads of this cycle see it.
    assign eff_row = tag_wr_i ? tag_fields_i : row_q;
    assign eff_cnt = tag_wr_i ? CNT_W'(NUM_FIELDS) : cnt_q;

    always_comb begin
        int taken;
        taken = 0;
        for (int s = 0; s < SLOTS; s++) begin
            hint_arr[s] = '0;
            if (rd_i[s]) begin
                if (taken < NUM_FIELDS)
                    hint_arr[s] = eff_row[taken*FIELD_W +: FIELD_W];
                taken++;
            end
        end
        nread = CNT_W'(taken);
        row_d = eff_row >> (FIELD_W * taken);
        cnt_d = (eff_cnt > nread) ? eff_cnt - nread : '0;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_hint_out
        assign hint_o[g*FIELD_W +: FIELD_W] = hint_arr[g];
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (tag_wr_i) state_d = ST_HOLD;
            ST_HOLD:  if (!tag_wr_i && (cnt_d == '0)) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            cnt_q <= '0;
        end else begin
            row_q <= row_d;
            cnt_q <= cnt_d;
        end
    end

    a_r3_empty_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_EMPTY |-> row_q == '0);

    a_r7_tag_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_wr_i && rd_i[0]) |-> hint_o[FIELD_W-1:0] == tag_fields_i[FIELD_W-1:0]);

    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_wr_i && rd_i == '0) |=> $stable(row_q));

    a_r5_pair_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!tag_wr_i && (&rd_i)) |=> row_q == ($past(row_q) >> (FIELD_W * SLOTS)));
endmodule

// File: rtl/mhint_annot_unit.sv
module mhint_annot_unit #(
    parameter int FIELD_W    = 4,
    parameter int NUM_FIELDS = 6,
    parameter int IMM_W      = 26,
    parameter int MEM_SLOTS  = 2,
    parameter int GRP_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tag_wr_i,
    input  logic [IMM_W-1:0]             tag_imm_i,
    input  logic [MEM_SLOTS-1:0]         mem_rd_i,
    output logic [MEM_SLOTS*FIELD_W-1:0] mem_hint_o,
    input  logic [GRP_W-1:0]             grp_tag_i,
    input  logic [GRP_W-1:0]             grp_mem_i,
    output logic                         issue_stall_o
);
    localparam int STORE_W = FIELD_W * NUM_FIELDS;

    logic [STORE_W-1:0] tag_fields;
    logic               unused_imm_hi;

    assign tag_fields    = tag_imm_i[STORE_W-1:0];
    assign unused_imm_hi = ^tag_imm_i[IMM_W-1:STORE_W];

    mhint_store #(
        .FIELD_W   (FIELD_W),
        .NUM_FIELDS(NUM_FIELDS),
        .SLOTS     (MEM_SLOTS)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .tag_wr_i    (tag_wr_i),
        .tag_fields_i(tag_fields),
        .rd_i        (mem_rd_i),
        .hint_o      (mem_hint_o)
    );

    mhint_interlock #(
        .GRP_W(GRP_W)
    ) u_interlock (
        .grp_tag_i(grp_tag_i),
        .grp_mem_i(grp_mem_i),
        .stall_o  (issue_stall_o)
    );

    a_r10_no_tag_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        grp_tag_i == '0 |-> !issue_stall_o);

    a_r9_oldest_tag_free: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_tag_i == GRP_W'(1)) |-> !issue_stall_o);
endmodule

// File: tb/mhint_annot_unit_bench.sv
module mhint_annot_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tag_wr_i;
    logic [25:0] tag_imm_i;
    logic [1:0]  mem_rd_i;
    logic [7:0]  mem_hint_o;
    logic [3:0]  grp_tag_i, grp_mem_i;
    logic        issue_stall_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int model_q[$];

    always #10 clk = ~clk;

    mhint_annot_unit u_mhint_annot_unit (
        .clk(clk), .rst_n(rst_n), .tag_wr_i(tag_wr_i), .tag_imm_i(tag_imm_i),
        .mem_rd_i(mem_rd_i), .mem_hint_o(mem_hint_o), .grp_tag_i(grp_tag_i),
        .grp_mem_i(grp_mem_i), .issue_stall_o(issue_stall_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare mid-low phase, model advances.
    task automatic step(string req, bit tw, logic [25:0] imm, logic [1:0] rd,
                        logic [3:0] gt, logic [3:0] gm);
        int exp_h [2];
        bit older, exp_stall;
        @(negedge clk);
        tag_wr_i = tw; tag_imm_i = imm; mem_rd_i = rd;
        grp_tag_i = gt; grp_mem_i = gm;
        #5;
        if (tw) begin
            model_q.delete();
            for (int i = 0; i < 6; i++) model_q.push_back((imm >> (4*i)) & 15);
        end
        for (int s = 0; s < 2; s++) begin
            exp_h[s] = 0;
            if (rd[s] && model_q.size() > 0) exp_h[s] = model_q.pop_front();
        end
        older = 0; exp_stall = 0;
        for (int i = 0; i < 4; i++) begin
            if (gt[i] && older) exp_stall = 1;
            if (gm[i]) older = 1;
        end
        check(req, int'(mem_hint_o[3:0]), exp_h[0]);
        check(req, int'(mem_hint_o[7:4]), exp_h[1]);
        check(exp_stall ? "R9" : "R10", int'(issue_stall_o), int'(exp_stall));
    endtask

    initial begin
        #4000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; tag_wr_i = 0; tag_imm_i = '0; mem_rd_i = '0;
        grp_tag_i = '0; grp_mem_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state gives default hints
        step("R1", 0, '0, 2'b11, 4'b0000, 4'b0000);
        step("R1", 0, '0, 2'b01, 4'b0000, 4'b1111);
        // R8 + R4: load with spare top bits set, no reads
        step("R8", 1, 26'h3_654321, 2'b00, 4'b0000, 4'b0000);
        // R2: single reads in order
        for (int i = 0; i < 6; i++) step("R2", 0, '0, 2'b01, 4'b0000, 4'b0000);
        // R3: zero fill afterwards
        step("R3", 0, '0, 2'b01, 4'b0000, 4'b0000);
        step("R3", 0, '0, 2'b11, 4'b0000, 4'b0000);
        // R4: spare bits differ, fields identical
        step("R4", 1, 26'h2_00000F, 2'b01, 4'b0000, 4'b0000);
        step("R4", 1, 26'h1_00000F, 2'b01, 4'b0000, 4'b0000);
        // R5: dual reads
        step("R5", 1, 26'h0_ABCDEF, 2'b00, 4'b0000, 4'b0000);
        for (int i = 0; i < 4; i++) step("R5", 0, '0, 2'b11, 4'b0000, 4'b0000);
        // R6: lone slot-1 read
        step("R6", 1, 26'h0_987654, 2'b00, 4'b0000, 4'b0000);
        step("R6", 0, '0, 2'b10, 4'b0000, 4'b0000);
        step("R6", 0, '0, 2'b01, 4'b0000, 4'b0000);
        // R7: reload with coincident reads discards leftovers
        step("R7", 1, 26'h0_13579B, 2'b11, 4'b0000, 4'b0000);
        step("R7", 0, '0, 2'b11, 4'b0000, 4'b0000);
        step("R7", 1, 26'h0_2468AC, 2'b01, 4'b0000, 4'b0000);
        step("R7", 0, '0, 2'b11, 4'b0000, 4'b0000);
        // R9 / R10 interlock patterns
        step("R9", 0, '0, 2'b00, 4'b0100, 4'b0001);
        step("R9", 0, '0, 2'b00, 4'b0010, 4'b1001);
        step("R9", 0, '0, 2'b00, 4'b1000, 4'b0100);
        step("R10", 0, '0, 2'b00, 4'b0001, 4'b1110);
        step("R10", 0, '0, 2'b00, 4'b0000, 4'b1111);
        step("R10", 0, '0, 2'b00, 4'b0100, 4'b1000);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] gt;
            logic [3:0] gm;
            gt = 4'(1 << ($urandom % 4)) & {4{($urandom % 2) == 1}};
            gm = 4'($urandom) & ~gt;
            step("R2", ($urandom % 5) == 0, 26'($urandom), 2'($urandom), gt, gm);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule